// File: doc/BRIEF.md
# Digital LDO Power-Switch Shift Controller

This block steers the pass-device array of an all-digital low-dropout regulator. It is built as a chain of stages, and each stage owns one power-switch gate. A single request token travels along the chain. When the regulator output sits below its reference, the stage holding the token closes its switch and hands the token to the right. When the output sits above the reference, the token steps back one stage and that stage opens its switch. The closed switches therefore always form a contiguous run starting at stage 0. Their number changes by at most one per step strobe, and the step strobe stands in for the self-timed delay of a stage.

A voltage-scaling controller drives the enable input. A rising edge of enable places the token at the head of the chain. Dropping enable opens every switch and withdraws the token. At the two ends the token is held back rather than lost. Once the token has bounced between the same two adjacent stages often enough, the block raises a lock flag and freezes the switches until enable falls.

Top module: `ldo_switch_chain`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every bit of `sw_on` is 0 and `locked` is 0.
- R2: A clock edge that samples `en` low clears `sw_on` and `locked` after that edge. While `en` is low, `step` has no effect.
- R3: The first clock edge that samples `en` high after it was low places the token at stage 0. That edge changes no switch.
- R4: On a step with `cmp_low`=1, the lowest open switch closes (bit index = number of closed switches), and the token moves one stage right.
- R5: On a step with `cmp_low`=0, the highest closed switch opens, and the token moves one stage left.
- R6: An edge without `step` leaves `sw_on` and `locked` unchanged while `en` stays high.
- R7: With all switches closed and `cmp_low`=1, further steps change nothing. The token is kept, so a later step with `cmp_low`=0 opens switch STAGES-1.
- R8: With all switches open and `cmp_low`=0, further steps change nothing. The token is kept at the head, so a later step with `cmp_low`=1 closes switch 0.
- R9: A reversal is a step whose direction differs from the previous moving step. When a reversal occurs at the stage adjacent to the previous reversal, and the previous reversal was also adjacent to the one before it, `locked` rises after that step. The step itself changes no switch.
- R10: While `locked` is 1, steps change neither `sw_on` nor `locked`, whatever `cmp_low` is, until `en` falls. A later rising edge of `en` starts a fresh run.
- R11: `sw_on` always has the form 2^k-1 (a contiguous run of ones from bit 0), and one edge changes at most one bit of it while `en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable from the voltage-scaling controller |
| cmp_low | input | 1 | Comparator result, 1 when the output is below the reference |
| step | input | 1 | One-cycle strobe that lets the token advance by one stage |
| sw_on | output | STAGES | Switch enables, bit i closes the switch of stage i |
| locked | output | 1 | Set once the token oscillates between two adjacent stages |

## Verification
The bench drives the comparator from a load target so the chain closes a real loop. It aims at both ends of the chain: a design that drops the token at the terminal or head stage would never reopen switch STAGES-1 or never close switch 0 again. The lock pattern is hit with small targets. A design that counts non-adjacent reversals would lock too early or never lock, and one that applies the locking step would end one switch short. It also toggles enable in mid-run and during a lock. A design that keeps stale reversal history would lock after too few bounces on the next run.

// File: rtl/ldo_switch_chain.sv
module ldo_switch_chain #(
  parameter int STAGES = 128,
  localparam int PW = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmp_low,
  input  logic              step,
  output logic [STAGES-1:0] sw_on,
  output logic              locked
);

  localparam logic [PW-1:0] LAST = PW'(STAGES);

  logic          en_q;
  logic          tok;
  logic [PW-1:0] pos;
  logic          dir;
  logic          dir_v;
  logic          rev_v;
  logic [PW-1:0] rev_pos;
  logic [1:0]    adj_cnt;

  logic              can_move, act, is_rev, adj, lock_now, apply;
  logic [STAGES-1:0] sw_d;

  assign can_move = cmp_low ? (pos != LAST) : (pos != '0);
  assign act      = en && en_q && tok && !locked && step && can_move;
  assign is_rev   = dir_v && (dir != cmp_low);
  assign adj      = rev_v && ((pos == rev_pos + 1'b1) || (rev_pos == pos + 1'b1));
  assign lock_now = act && is_rev && adj && (adj_cnt != 2'd0);
  assign apply    = act && !lock_now;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic close_me, open_me;
    assign close_me = apply &&  cmp_low && (pos == PW'(i));
    assign open_me  = apply && !cmp_low && (pos == PW'(i + 1));
    assign sw_d[i]  = close_me ? 1'b1 : (open_me ? 1'b0 : sw_on[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      tok     <= 1'b0;
      pos     <= '0;
      dir     <= 1'b0;
      dir_v   <= 1'b0;
      rev_v   <= 1'b0;
      rev_pos <= '0;
      adj_cnt <= '0;
      locked  <= 1'b0;
      sw_on   <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        tok     <= 1'b0;
        pos     <= '0;
        dir_v   <= 1'b0;
        rev_v   <= 1'b0;
        adj_cnt <= '0;
        locked  <= 1'b0;
        sw_on   <= '0;
      end else if (!en_q) begin
        tok     <= 1'b1;
        pos     <= '0;
        dir_v   <= 1'b0;
        rev_v   <= 1'b0;
        adj_cnt <= '0;
        locked  <= 1'b0;
      end else if (lock_now) begin
        locked <= 1'b1;
      end else if (apply) begin
        sw_on <= sw_d;
        pos   <= cmp_low ? pos + 1'b1 : pos - 1'b1;
        dir   <= cmp_low;
        dir_v <= 1'b1;
        if (is_rev) begin
          rev_v   <= 1'b1;
          rev_pos <= pos;
          adj_cnt <= adj ? adj_cnt + 1'b1 : 2'd0;
        end
      end
    end
  end

  // R2
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sw_on == '0) && !locked);

  // R6
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(sw_on) && $stable(locked));

  // R10
  frozen_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && locked) |=> $stable(sw_on) && locked);

  // R11
  one_bit_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($countones(sw_on ^ $past(sw_on)) <= 1));

  // R11
  thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_on & (sw_on + 1'b1)) == '0));

  // R3
  inject_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q) |=> (sw_on == '0));

endmodule

// File: tb/ldo_switch_chain_test.sv
`timescale 1ns/1ps
module ldo_switch_chain_test;
  localparam int N = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cmp_low = 1'b0, step = 1'b0;
  logic [N-1:0] sw_on;
  logic locked;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [N-1:0] m_sw;
  int  m_pos, m_rev, m_cnt;
  bit  m_tok, m_dir, m_dirv, m_revv, m_lock, m_en;
  int  target;

  ldo_switch_chain #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp_low(cmp_low), .step(step),
    .sw_on(sw_on), .locked(locked)
  );

  always #5 clk = ~clk;

  function automatic bit want_low();
    return $countones(m_sw) < target;
  endfunction

  task automatic model_reset();
    m_sw = '0; m_pos = 0; m_rev = 0; m_cnt = 0;
    m_tok = 0; m_dir = 0; m_dirv = 0; m_revv = 0; m_lock = 0; m_en = 0;
  endtask

  task automatic model_edge(bit e, bit s, bit lo);
    bit mv, rv, adj, d;
    int nc;
    if (!e) begin
      m_sw = '0; m_tok = 0; m_pos = 0; m_dirv = 0; m_revv = 0; m_cnt = 0; m_lock = 0;
    end else if (!m_en) begin
      m_tok = 1; m_pos = 0; m_dirv = 0; m_revv = 0; m_cnt = 0; m_lock = 0;
    end else if (s && m_tok && !m_lock) begin
      mv = lo ? (m_pos < N) : (m_pos > 0);
      if (mv) begin
        d = lo;
        rv = m_dirv && (d != m_dir);
        adj = m_revv && ((m_pos == m_rev + 1) || (m_rev == m_pos + 1));
        nc = adj ? m_cnt + 1 : 0;
        if (rv && nc >= 2) m_lock = 1;
        else begin
          if (rv) begin m_revv = 1; m_rev = m_pos; m_cnt = nc; end
          if (lo) begin m_sw[m_pos] = 1'b1; m_pos++; end
          else begin m_pos--; m_sw[m_pos] = 1'b0; end
          m_dir = d; m_dirv = 1;
        end
      end
    end
    m_en = e;
  endtask

  task automatic check(string tag, bit ok, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " sw_on"}, sw_on === m_sw, sw_on, m_sw);
    check({tag, " locked"}, locked === m_lock, N'(locked), N'(m_lock));
  endtask

  // drive at negedge, edge acts, compare at next negedge
  task automatic cyc(bit e, bit s, bit lo, string tag);
    en = e; step = s; cmp_low = lo;
    model_edge(e, s, lo);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic auto_step(string tag);
    cyc(1, 1, want_low(), tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    target = 0;
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R1 after release");

    // R2: steps with en low ignored
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, "R2 step while disabled");
    // R3: injection edge changes nothing
    cyc(1, 1, 1, "R3 enable rising edge");
    // R4: first closing step
    cyc(1, 1, 1, "R4 close switch 0");
    check("R4 single bit", sw_on === N'(1), sw_on, N'(1));
    // R6: idle cycles
    for (int i = 0; i < 4; i++) cyc(1, 0, i[0], "R6 no step");
    // R4/R5/R9: lock at target 3
    target = 3;
    for (int i = 0; i < 10; i++) auto_step("R9 converge to 3");
    check("R9 locked at target 3", locked === 1'b1 && sw_on === N'(7), sw_on, N'(7));
    // R10: frozen
    for (int i = 0; i < 6; i++) cyc(1, 1, i[0], "R10 frozen while locked");
    // R2: disable clears
    cyc(0, 0, 1, "R2 disable clears");
    check("R2 all open", sw_on === '0 && locked === 1'b0, sw_on, '0);
    cyc(1, 0, 0, "R3 re-enable");
    // R5: open from 5
    target = 5;
    for (int i = 0; i < 5; i++) auto_step("R4 close toward 5");
    cyc(1, 1, 0, "R5 open highest");
    check("R5 four closed", sw_on === N'(15), sw_on, N'(15));
    // R8: head boundary
    cyc(0, 0, 0, "R2 disable"); cyc(1, 0, 0, "R3 enable");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, "R8 held at head");
    cyc(1, 1, 1, "R8 head recovers");
    check("R8 switch 0 closed", sw_on === N'(1), sw_on, N'(1));
    // R7: terminal boundary
    cyc(0, 0, 0, "R2 disable"); cyc(1, 0, 0, "R3 enable");
    for (int i = 0; i < N + 4; i++) cyc(1, 1, 1, "R7 fill and hold at end");
    check("R7 all closed", &sw_on, sw_on, '1);
    cyc(1, 1, 0, "R7 end recovers");
    check("R7 top switch open", sw_on === {1'b0, {(N-1){1'b1}}}, sw_on, {1'b0, {(N-1){1'b1}}});

    // random runs against the model
    for (int run = 0; run < 12; run++) begin
      target = $urandom_range(0, N);
      cyc(0, 0, 0, "R2 run start");
      cyc(1, 0, 0, "R3 run enable");
      for (int c = 0; c < 400; c++) begin
        bit s;
        s = ($urandom_range(0, 9) < 7);
        if ($urandom_range(0, 99) < 3) target = $urandom_range(0, N);
        if ($urandom_range(0, 199) == 0) begin
          cyc(0, s, want_low(), "R2 random disable");
          cyc(1, 0, 0, "R3 random enable");
        end else begin
          cyc(1, s, want_low(), s ? "R4 R5 R9 random step" : "R6 random idle");
        end
        check("R11 thermometer", (sw_on & (sw_on + 1'b1)) == '0, sw_on, '0);
        if (m_lock && $urandom_range(0, 9) == 0) break;
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule